// File: doc/BRIEF.md
# Processor Interrupt Front End

This block sits between an interrupt distributor and one processor. Each cycle the distributor offers one candidate interrupt (a valid flag, an identifier and a priority). The block decides whether that candidate may interrupt the processor, and drives a registered request line when it may. A lower priority value means a more urgent interrupt. The candidate must be strictly more urgent than both a software-written priority mask and the priority of the interrupt now being serviced.

When the processor acknowledges, the block returns the identifier of the qualifying candidate. It also sends an activate pulse back to the distributor, so that the interrupt moves from pending to active, and it pushes the identifier and priority onto a nesting stack of four entries. The top of that stack sets the running priority. An idle stack gives the least urgent level, all ones. When the processor writes an end-of-interrupt whose identifier matches the top of the stack, the entry is popped and a deactivate pulse moves the interrupt to inactive. Any other end-of-interrupt is dropped. If no candidate qualifies, an acknowledge returns the spurious code 1023.

The controller has three states. IDLE means no request. SIGNAL means the request is high. BLANK is the one-cycle pause after an acknowledge. The transitions are:
- IDLE→SIGNAL when a candidate qualifies.
- SIGNAL→IDLE when it stops qualifying.
- Any state→BLANK on an acknowledge.
- BLANK→SIGNAL or BLANK→IDLE, depending on whether a candidate qualifies one cycle later.

Top module: `irq_cpu_frontend`

## Requirements
- R1: `irq` goes high one clock after a cycle in which `cand_valid` is 1, `cand_prio` is numerically less than the mask and less than the running priority, and the nesting stack is not full.
- R2: A candidate whose priority equals the mask or the running priority does not raise `irq`.
- R3: An acknowledge while a candidate qualifies produces `ack_vld` one clock later with `ack_id` equal to the candidate ID. In the same cycle it produces `act_vld` with `act_id` equal to that ID.
- R4: After an acknowledge, the running priority equals the acknowledged priority, so candidates of equal or lower urgency cannot raise `irq` until the matching end-of-interrupt.
- R5: `irq` is low in the clock after any acknowledge, and rises again only once a qualifying candidate is evaluated.
- R6: An acknowledge without a qualifying candidate returns `ack_id` = 1023 with no `act_vld` and leaves the running priority unchanged.
- R7: An end-of-interrupt whose ID equals the top stack entry produces `deact_vld` with `deact_id` equal to that ID one clock later. It restores the running priority to the entry below, or to 255 when the stack is empty.
- R8: An end-of-interrupt with any other ID, with an empty stack, or in the same cycle as an acknowledge, is ignored: no `deact_vld` and no change to the running priority.
- R9: Up to four acknowledged interrupts may nest. With four on the stack, `irq` stays low and an acknowledge returns 1023.
- R10: `mask_we` loads `mask_wdata` into the priority mask. The mask resets to 0, which blocks every candidate.
- R11: After reset, `irq`, `ack_vld`, `act_vld` and `deact_vld` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cand_valid | input | 1 | Distributor offers a candidate |
| cand_id | input | 10 | Candidate identifier |
| cand_prio | input | 8 | Candidate priority, lower is more urgent |
| mask_we | input | 1 | Priority mask write strobe |
| mask_wdata | input | 8 | New priority mask |
| ack_req | input | 1 | Processor acknowledge strobe |
| eoi_req | input | 1 | End-of-interrupt strobe |
| eoi_id | input | 10 | Identifier written with end-of-interrupt |
| irq | output | 1 | Interrupt request to the processor |
| ack_vld | output | 1 | Acknowledge response valid |
| ack_id | output | 10 | Acknowledged identifier or 1023 |
| act_vld | output | 1 | Pending-to-active request to distributor |
| act_id | output | 10 | Identifier to activate |
| deact_vld | output | 1 | Active-to-inactive request to distributor |
| deact_id | output | 10 | Identifier to deactivate |

## Verification
The checker assumes that the distributor never offers identifier 1023 as a valid candidate. It also assumes that acknowledge and end-of-interrupt are single-cycle strobes driven away from the clock edge. Its properties also take for granted that the candidate inputs are stable during the cycle they are sampled. The stimulus keeps to these assumptions: it changes the candidate only on falling edges, uses identifiers from 40 to 54, and pulses each strobe for exactly one cycle. The expected stack contents are tracked by the order of the acknowledges in the bench.

// File: rtl/irqfe_pkg.sv
package irqfe_pkg;

    // Identifier returned when nothing may be acknowledged
    localparam int SPURIOUS_ID = 1023;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SIGNAL = 2'd1,
        ST_BLANK  = 2'd2
    } fe_state_e;

endpackage

// File: rtl/irqfe_nest_stack.sv
module irqfe_nest_stack #(
    parameter int ID_W   = 10,
    parameter int PRIO_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             push,
    input  logic [ID_W-1:0]                  push_id,
    input  logic [PRIO_W-1:0]                push_prio,
    input  logic                             pop,
    output logic [ID_W-1:0]                  top_id,
    output logic [PRIO_W-1:0]                top_prio,
    output logic                             empty,
    output logic                             full,
    output logic [$clog2(DEPTH+1)-1:0]       depth_o
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [CNT_W-1:0]  count_q;
    logic [ID_W-1:0]   id_q   [DEPTH];
    logic [PRIO_W-1:0] prio_q [DEPTH];
    logic [IDX_W-1:0]  top_idx;

    assign empty   = (count_q == '0);
    assign full    = (count_q == CNT_W'(DEPTH));
    assign depth_o = count_q;
    assign top_idx = empty ? '0 : IDX_W'(count_q - CNT_W'(1));
    assign top_id   = id_q[top_idx];
    assign top_prio = prio_q[top_idx];

    // One storage slot per nesting level
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                id_q[g]   <= '0;
                prio_q[g] <= '1;
            end else if (push && !full && (count_q == CNT_W'(g))) begin
                id_q[g]   <= push_id;
                prio_q[g] <= push_prio;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (push && !full) begin
            count_q <= count_q + CNT_W'(1);
        end else if (pop && !empty) begin
            count_q <= count_q - CNT_W'(1);
        end
    end

endmodule

// File: rtl/irqfe_qualify.sv
module irqfe_qualify #(
    parameter int PRIO_W = 8
) (
    input  logic              cand_valid,
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic [PRIO_W-1:0] mask_prio,
    input  logic [PRIO_W-1:0] run_prio,
    input  logic              stack_full,
    output logic              hit
);

    logic beats_mask;
    logic beats_running;

    always_comb begin
        beats_mask    = (cand_prio < mask_prio);
        beats_running = (cand_prio < run_prio);
        hit           = cand_valid && !stack_full && beats_mask && beats_running;
    end

endmodule

// File: rtl/irqfe_ctrl.sv
module irqfe_ctrl
    import irqfe_pkg::*;
#(
    parameter int ID_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hit,
    input  logic [ID_W-1:0] cand_id,
    input  logic            ack_req,
    input  logic            eoi_req,
    input  logic [ID_W-1:0] eoi_id,
    input  logic [ID_W-1:0] top_id,
    input  logic            stack_empty,
    output logic            push,
    output logic            pop,
    output logic            irq,
    output logic            ack_vld,
    output logic [ID_W-1:0] ack_id,
    output logic            act_vld,
    output logic [ID_W-1:0] act_id,
    output logic            deact_vld,
    output logic [ID_W-1:0] deact_id
);

    localparam logic [ID_W-1:0] SPUR_ID = ID_W'(SPURIOUS_ID);

    fe_state_e state_q;
    fe_state_e state_d;

    // Stack commands, resolved in the same cycle as the strobes
    assign push = ack_req && hit;
    assign pop  = eoi_req && !ack_req && !stack_empty && (eoi_id == top_id);

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ack_req)  state_d = ST_BLANK;
                else if (hit) state_d = ST_SIGNAL;
            end
            ST_SIGNAL: begin
                if (ack_req)   state_d = ST_BLANK;
                else if (!hit) state_d = ST_IDLE;
            end
            ST_BLANK: begin
                if (ack_req)  state_d = ST_BLANK;
                else if (hit) state_d = ST_SIGNAL;
                else          state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign irq = (state_q == ST_SIGNAL);

    // Registered handshake outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_vld   <= 1'b0;
            ack_id    <= SPUR_ID;
            act_vld   <= 1'b0;
            act_id    <= '0;
            deact_vld <= 1'b0;
            deact_id  <= '0;
        end else begin
            ack_vld   <= ack_req;
            ack_id    <= push ? cand_id : SPUR_ID;
            act_vld   <= push;
            act_id    <= cand_id;
            deact_vld <= pop;
            deact_id  <= eoi_id;
        end
    end

endmodule

// File: rtl/irq_cpu_frontend.sv
module irq_cpu_frontend #(
    parameter int ID_W       = 10,
    parameter int PRIO_W     = 8,
    parameter int NEST_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cand_valid,
    input  logic [ID_W-1:0]   cand_id,
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic              mask_we,
    input  logic [PRIO_W-1:0] mask_wdata,
    input  logic              ack_req,
    input  logic              eoi_req,
    input  logic [ID_W-1:0]   eoi_id,
    output logic              irq,
    output logic              ack_vld,
    output logic [ID_W-1:0]   ack_id,
    output logic              act_vld,
    output logic [ID_W-1:0]   act_id,
    output logic              deact_vld,
    output logic [ID_W-1:0]   deact_id
);

    localparam int CNT_W = $clog2(NEST_DEPTH + 1);

    logic [PRIO_W-1:0] mask_q;
    logic [PRIO_W-1:0] run_prio;
    logic [ID_W-1:0]   top_id;
    logic [PRIO_W-1:0] top_prio;
    logic              stack_empty;
    logic              stack_full;
    logic [CNT_W-1:0]  nest_depth;
    logic              hit;
    logic              push;
    logic              pop;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_wdata;
    end

    assign run_prio = stack_empty ? '1 : top_prio;

    irqfe_qualify #(.PRIO_W(PRIO_W)) u_qual (
        .cand_valid (cand_valid),
        .cand_prio  (cand_prio),
        .mask_prio  (mask_q),
        .run_prio   (run_prio),
        .stack_full (stack_full),
        .hit        (hit)
    );

    irqfe_nest_stack #(.ID_W(ID_W), .PRIO_W(PRIO_W), .DEPTH(NEST_DEPTH)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_id   (cand_id),
        .push_prio (cand_prio),
        .pop       (pop),
        .top_id    (top_id),
        .top_prio  (top_prio),
        .empty     (stack_empty),
        .full      (stack_full),
        .depth_o   (nest_depth)
    );

    irqfe_ctrl #(.ID_W(ID_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit         (hit),
        .cand_id     (cand_id),
        .ack_req     (ack_req),
        .eoi_req     (eoi_req),
        .eoi_id      (eoi_id),
        .top_id      (top_id),
        .stack_empty (stack_empty),
        .push        (push),
        .pop         (pop),
        .irq         (irq),
        .ack_vld     (ack_vld),
        .ack_id      (ack_id),
        .act_vld     (act_vld),
        .act_id      (act_id),
        .deact_vld   (deact_vld),
        .deact_id    (deact_id)
    );

endmodule

// File: rtl/irqfe_checker.sv
module irqfe_checker #(
    parameter int ID_W       = 10,
    parameter int PRIO_W     = 8,
    parameter int NEST_DEPTH = 4
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           cand_valid,
    input logic [PRIO_W-1:0]              cand_prio,
    input logic [PRIO_W-1:0]              mask_q,
    input logic [PRIO_W-1:0]              run_prio,
    input logic                           ack_req,
    input logic                           eoi_req,
    input logic                           irq,
    input logic                           ack_vld,
    input logic [ID_W-1:0]                ack_id,
    input logic                           act_vld,
    input logic [ID_W-1:0]                act_id,
    input logic                           deact_vld,
    input logic [$clog2(NEST_DEPTH+1)-1:0] nest_depth
);

    localparam logic [ID_W-1:0] SPUR_ID = ID_W'(irqfe_pkg::SPURIOUS_ID);

    p_irq_needs_cand_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(cand_valid));

    p_irq_strict_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(cand_prio) < $past(mask_q)) && ($past(cand_prio) < $past(run_prio)));

    p_ack_answer_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |=> ack_vld);

    p_act_matches_r3: assert property (@(posedge clk) disable iff (!rst_n)
        act_vld |-> ack_vld && (ack_id == act_id));

    p_ack_blanks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |=> !irq);

    p_spurious_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_vld && (ack_id == SPUR_ID)) |-> !act_vld);

    p_deact_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        deact_vld |-> $past(eoi_req) && !$past(ack_req));

    p_run_moves_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(run_prio) |-> (act_vld || deact_vld));

    p_depth_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        nest_depth <= ($clog2(NEST_DEPTH+1))'(NEST_DEPTH));

    p_one_update_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(act_vld && deact_vld));

endmodule

bind irq_cpu_frontend irqfe_checker #(
    .ID_W(ID_W), .PRIO_W(PRIO_W), .NEST_DEPTH(NEST_DEPTH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cand_valid (cand_valid),
    .cand_prio  (cand_prio),
    .mask_q     (mask_q),
    .run_prio   (run_prio),
    .ack_req    (ack_req),
    .eoi_req    (eoi_req),
    .irq        (irq),
    .ack_vld    (ack_vld),
    .ack_id     (ack_id),
    .act_vld    (act_vld),
    .act_id     (act_id),
    .deact_vld  (deact_vld),
    .nest_depth (nest_depth)
);

// File: tb/irq_cpu_frontend_test.sv
module irq_cpu_frontend_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cand_valid = 1'b0;
    logic [9:0] cand_id = '0;
    logic [7:0] cand_prio = '0;
    logic       mask_we = 1'b0;
    logic [7:0] mask_wdata = '0;
    logic       ack_req = 1'b0;
    logic       eoi_req = 1'b0;
    logic [9:0] eoi_id = '0;
    logic       irq, ack_vld, act_vld, deact_vld;
    logic [9:0] ack_id, act_id, deact_id;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        int    kind;   // 0 ack response, 1 activate, 2 deactivate
        int    id;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    irq_cpu_frontend uut (
        .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_id(cand_id),
        .cand_prio(cand_prio), .mask_we(mask_we), .mask_wdata(mask_wdata),
        .ack_req(ack_req), .eoi_req(eoi_req), .eoi_id(eoi_id), .irq(irq),
        .ack_vld(ack_vld), .ack_id(ack_id), .act_vld(act_vld), .act_id(act_id),
        .deact_vld(deact_vld), .deact_id(deact_id)
    );

    task automatic compare_item(input int kind, input int id);
        exp_t e;
        checks++;
        if (sb.size() == 0) begin
            fails++;
            $display("FAIL unexpected pulse kind %0d id %0d, expected nothing (R8/R6)", kind, id);
        end else begin
            e = sb.pop_front();
            if (e.kind != kind || e.id != id) begin
                fails++;
                $display("FAIL %s: got kind %0d id %0d, expected kind %0d id %0d",
                         e.tag, kind, id, e.kind, e.id);
            end
        end
    endtask

    // Monitor: pops expectations as results appear
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (ack_vld)   compare_item(0, int'(ack_id));
            if (act_vld)   compare_item(1, int'(act_id));
            if (deact_vld) compare_item(2, int'(deact_id));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_irq(input logic exp, input string tag);
        checks++;
        if (irq !== exp) begin
            fails++;
            $display("FAIL %s: irq=%b expected %b", tag, irq, exp);
        end
    endtask

    task automatic offer(input logic v, input int id, input int p);
        cand_valid = v;
        cand_id    = 10'(id);
        cand_prio  = 8'(p);
    endtask

    task automatic set_mask(input int m);
        mask_we = 1'b1; mask_wdata = 8'(m);
        tick(1);
        mask_we = 1'b0;
    endtask

    task automatic do_ack(input int exp_id, input string tag);
        exp_t e;
        e.kind = 0; e.id = exp_id; e.tag = tag;
        sb.push_back(e);
        if (exp_id != 1023) begin
            e.kind = 1;
            sb.push_back(e);
        end
        ack_req = 1'b1;
        tick(1);
        ack_req = 1'b0;
        check_irq(1'b0, "R5 irq low after acknowledge");
    endtask

    task automatic do_eoi(input int id, input bit expect_deact, input string tag);
        exp_t e;
        if (expect_deact) begin
            e.kind = 2; e.id = id; e.tag = tag;
            sb.push_back(e);
        end
        eoi_req = 1'b1; eoi_id = 10'(id);
        tick(1);
        eoi_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R11 reset state
        checks++;
        if (irq !== 1'b0 || ack_vld !== 1'b0 || act_vld !== 1'b0 || deact_vld !== 1'b0) begin
            fails++;
            $display("FAIL R11 reset outputs irq=%b ack=%b act=%b deact=%b, expected 0",
                     irq, ack_vld, act_vld, deact_vld);
        end
        // R10: reset mask blocks even the most urgent candidate
        offer(1'b1, 40, 8'h00);
        tick(2);
        check_irq(1'b0, "R10 reset mask blocks");

        set_mask(8'hF0);
        offer(1'b1, 40, 8'h80);
        tick(2);
        check_irq(1'b1, "R1 qualifying candidate");
        offer(1'b1, 40, 8'hF0);
        tick(2);
        check_irq(1'b0, "R2 equal to mask");
        offer(1'b1, 40, 8'h80);
        tick(2);
        check_irq(1'b1, "R1 qualifying again");
        do_ack(40, "R3 acknowledge 40");
        tick(3);
        check_irq(1'b0, "R4 running priority blocks same level");
        offer(1'b1, 44, 8'h80);
        tick(2);
        check_irq(1'b0, "R2 equal to running priority");

        // nested preemption
        offer(1'b1, 41, 8'h40);
        tick(2);
        check_irq(1'b1, "R1 more urgent preempts");
        do_ack(41, "R3 acknowledge 41");
        offer(1'b1, 42, 8'h60);
        tick(2);
        check_irq(1'b0, "R4 running 0x40 blocks 0x60");
        do_eoi(40, 1'b0, "R8 mismatched end");
        tick(2);
        check_irq(1'b0, "R8 mismatch leaves running priority");
        do_eoi(41, 1'b1, "R7 end of 41");
        tick(2);
        check_irq(1'b1, "R7 running restored to 0x80");
        do_ack(42, "R3 acknowledge 42");

        // spurious acknowledge
        offer(1'b0, 0, 0);
        tick(2);
        do_ack(1023, "R6 spurious");
        offer(1'b1, 43, 8'h50);
        tick(2);
        check_irq(1'b1, "R6 running unchanged by spurious");
        offer(1'b1, 43, 8'h60);
        tick(2);
        check_irq(1'b0, "R6 still at 0x60 level");
        // end in same cycle as acknowledge is dropped
        offer(1'b0, 0, 0);
        eoi_req = 1'b1; eoi_id = 10'd42;
        do_ack(1023, "R8 acknowledge beside end");
        eoi_req = 1'b0;
        do_eoi(42, 1'b1, "R7 end of 42");
        do_eoi(40, 1'b1, "R7 end of 40");
        do_eoi(40, 1'b0, "R8 end on empty stack");

        // fill the stack
        for (int k = 0; k < 4; k++) begin
            offer(1'b1, 50 + k, 8'h50 - 16 * k);
            tick(2);
            check_irq(1'b1, "R9 nesting level");
            do_ack(50 + k, "R9 nested acknowledge");
        end
        offer(1'b1, 54, 8'h10);
        tick(2);
        check_irq(1'b0, "R9 full stack blocks");
        do_ack(1023, "R9 full stack acknowledge");
        offer(1'b0, 0, 0);
        for (int k = 3; k >= 0; k--) begin
            do_eoi(50 + k, 1'b1, "R7 unwind");
        end
        offer(1'b1, 54, 8'h10);
        tick(2);
        check_irq(1'b1, "R7 idle running priority after unwind");
        set_mask(8'h10);
        tick(1);
        check_irq(1'b0, "R10 mask write 0x10 blocks 0x10");
        set_mask(8'h11);
        tick(1);
        check_irq(1'b1, "R10 mask write 0x11 admits 0x10");

        tick(3);
        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R3/R7 %0d expected results never appeared, expected 0", sb.size());
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule